// File: doc/BRIEF.md
# Windowed Sequence Occurrence Checker

This block is a synthesizable temporal monitor. Each cycle in which `startI` is high opens a new evaluation. The evaluation then watches the one-bit `operandI` over a window of cycles, counted forward from the cycle that opened it. The start cycle is offset 0, and the window runs from offset `WIN_START` to offset `WIN_END`. A compile-time operator decides what the operand has to do inside the window. It can be required at least once, on every cycle, on no cycle, or on at least `HIT_COUNT` cycles. The monitor gives its verdict as a one-cycle `matchO` or `failO` pulse.

Evaluations may overlap, so a new start can arrive while earlier ones are still open. A tracking parameter chooses how an operand hit is shared among them. In overlap tracking the hit counts for every open evaluation. In pipe tracking it counts only for the oldest evaluation that still needs one. A reporting parameter chooses between two behaviours: first-match ends an evaluation at the hit that satisfies it, while all-match reports every satisfying hit until the window closes. A fixed delay of D cycles is the at-least-once operator with both window bounds equal to D.

Top module: `occ_window_monitor`

## Requirements
- R1: With the at-least-once operator, an operand high on a cycle whose offset lies in [WIN_START:WIN_END] (offset 0 = the start cycle, WIN_START >= 1) produces `matchO` high on the following cycle. An operand high at any offset outside the window has no effect.
- R2: In all-match reporting, each window cycle with the operand high yields its own match pulse. For example, a [1:3] window with the operand high on offsets 1, 2 and 3 gives three pulses. Verdicts from several evaluations on the same cycle merge into one pulse.
- R3: In first-match reporting, an evaluation reports one match on its first satisfying hit and then closes, so later hits in its window produce nothing.
- R4: An at-least-once evaluation that ends offset WIN_END without a hit drives `failO` high on the following cycle. A satisfied one produces no fail.
- R5: With the count operator (`OP` = 3), a match is reported on the cycle after the HIT_COUNT-th hit in the window. Fewer hits by offset WIN_END give a fail on the following cycle.
- R6: With the always operator (`OP` = 1), the first window cycle with the operand low gives a fail on the following cycle and closes the evaluation. An operand high on every window cycle gives a match on the cycle after offset WIN_END.
- R7: With the never operator (`OP` = 2), the first window cycle with the operand high gives a fail on the following cycle and closes the evaluation. An operand low on every window cycle gives a match on the cycle after offset WIN_END.
- R8: In overlap tracking (`TRACK` = 0), one operand hit counts for every open evaluation whose window contains that cycle.
- R9: In pipe tracking (`TRACK` = 1), one operand hit counts only for the oldest in-window evaluation that is not yet satisfied. Younger evaluations get nothing from it.
- R10: With WIN_START = WIN_END = D, the at-least-once operator checks the operand at exactly offset D, and only there.
- R11: An active-low reset discards all open evaluations at once. No match or fail appears during reset or on the first two cycles after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | Opens a new evaluation; this cycle is offset 0 |
| operandI | input | 1 | Boolean operand that is watched |
| matchO | output | 1 | One-cycle pulse: an evaluation was satisfied |
| failO | output | 1 | One-cycle pulse: an evaluation was violated |

## Verification
The bench aims at the window edges: a hit at offset 0, a hit one cycle before the window opens, and a hit or miss exactly at offset WIN_END. A design that is off by one on either bound would match too early or fail an evaluation that was in fact satisfied. The bench also shares one hit between two overlapping evaluations and compares the two tracking modes. Pipe tracking that credited every evaluation would miss the expected fail, and overlap tracking that credited only one would raise a fail that should not appear. Further checks cover the following. An evaluation left open after a first match would give a second pulse. An always or never evaluation that stayed open after its fail would report again. A reset that kept a live evaluation would let it match after reset.

// File: rtl/occ_window_pkg.sv
package occ_window_pkg;

  // Windowed operator applied to the operand
  typedef enum logic [1:0] {
    OCC_ONCE   = 2'd0,
    OCC_ALWAYS = 2'd1,
    OCC_NEVER  = 2'd2,
    OCC_COUNT  = 2'd3
  } occ_op_e;

  // How one operand hit is shared among open evaluations
  typedef enum logic {
    TRK_OVERLAP = 1'b0,
    TRK_PIPE    = 1'b1
  } occ_track_e;

  // Strobes from control to the slot line, one per age slot
  typedef struct packed {
    logic credit;  // count one hit for this evaluation
    logic close;   // evaluation finished early, do not age it further
  } slot_strobe_t;

endpackage

// File: rtl/occ_slot_line.sv
// Age-ordered line of open evaluations. Slot i holds the evaluation launched
// i+1 cycles ago together with its saturating hit counter.
module occ_slot_line
  import occ_window_pkg::*;
#(
  parameter int SLOTS  = 3,
  parameter int TARGET = 1,
  localparam int CW    = $clog2(TARGET + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startI,
  input  slot_strobe_t [SLOTS-1:0]   strbI,
  output logic [SLOTS-1:0]           validO,
  output logic [SLOTS-1:0][CW-1:0]   cntO,
  output logic                       endLiveO,
  output logic [CW-1:0]              endCntO
);

  localparam logic [CW-1:0] CNT_SAT = CW'(TARGET);

  logic [SLOTS-1:0][CW-1:0] bumped;

  // Hit counter after this cycle's credit, saturating at the target
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      if (strbI[i].credit && (cntO[i] != CNT_SAT)) begin
        bumped[i] = cntO[i] + CW'(1);
      end else begin
        bumped[i] = cntO[i];
      end
    end
  end

  // State of the oldest slot as it leaves the line
  assign endLiveO = validO[SLOTS-1] & ~strbI[SLOTS-1].close;
  assign endCntO  = bumped[SLOTS-1];

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            validO[0] <= 1'b0;
            cntO[0]   <= '0;
          end else begin
            validO[0] <= startI;
            cntO[0]   <= '0;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            validO[i] <= 1'b0;
            cntO[i]   <= '0;
          end else begin
            validO[i] <= validO[i-1] & ~strbI[i-1].close;
            cntO[i]   <= bumped[i-1];
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/occ_window_ctrl.sv
// Window decode, hit arbitration and verdict registers.
module occ_window_ctrl
  import occ_window_pkg::*;
#(
  parameter int         SLOTS       = 3,
  parameter int         WIN_START   = 1,
  parameter int         TARGET      = 1,
  parameter occ_op_e    OP          = OCC_ONCE,
  parameter occ_track_e TRACK       = TRK_OVERLAP,
  parameter bit         FIRST_MATCH = 1'b0,
  localparam int        CW          = $clog2(TARGET + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       operandI,
  input  logic [SLOTS-1:0]           validI,
  input  logic [SLOTS-1:0][CW-1:0]   cntI,
  input  logic                       endLiveI,
  input  logic [CW-1:0]              endCntI,
  output slot_strobe_t [SLOTS-1:0]   strbO,
  output logic                       matchO,
  output logic                       failO
);

  localparam bit COUNTING = (OP == OCC_ONCE) || (OP == OCC_COUNT);

  // Slots whose age lies inside the window (age of slot i is i+1)
  function automatic logic [SLOTS-1:0] calcWinMask();
    logic [SLOTS-1:0] m;
    for (int i = 0; i < SLOTS; i++) begin
      m[i] = ((i + 1) >= WIN_START);
    end
    return m;
  endfunction

  localparam logic [SLOTS-1:0] WIN_MASK = calcWinMask();

  logic [SLOTS-1:0] live;
  logic [SLOTS-1:0] need;
  logic [SLOTS-1:0] reach;
  logic             taken;
  logic             badSample;
  logic             matchNext;
  logic             failNext;

  assign live = validI & WIN_MASK;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_need
      assign need[i] = live[i] && (int'(cntI[i]) < TARGET);
    end
  endgenerate

  assign badSample = (OP == OCC_NEVER) ? operandI : ~operandI;

  always_comb begin
    taken     = 1'b0;
    matchNext = 1'b0;
    failNext  = 1'b0;
    reach     = '0;
    // Oldest slot first so that pipe tracking credits the oldest need
    for (int i = SLOTS - 1; i >= 0; i--) begin
      strbO[i].credit = 1'b0;
      strbO[i].close  = 1'b0;
      if (COUNTING) begin
        if (operandI) begin
          if (TRACK == TRK_OVERLAP) begin
            strbO[i].credit = live[i];
          end else if (need[i] && !taken) begin
            strbO[i].credit = 1'b1;
            taken           = 1'b1;
          end
        end
        reach[i]       = strbO[i].credit && ((int'(cntI[i]) + 1) >= TARGET);
        strbO[i].close = FIRST_MATCH && reach[i];
        matchNext      = matchNext | reach[i];
      end else begin
        strbO[i].close = live[i] && badSample;
        failNext       = failNext | strbO[i].close;
      end
    end
    if (COUNTING) begin
      failNext = validI[SLOTS-1] && (int'(endCntI) < TARGET);
    end else begin
      matchNext = endLiveI;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchO <= 1'b0;
      failO  <= 1'b0;
    end else begin
      matchO <= matchNext;
      failO  <= failNext;
    end
  end

endmodule

// File: rtl/occ_window_monitor.sv
// Windowed occurrence monitor: thin top over slot line and control.
module occ_window_monitor
  import occ_window_pkg::*;
#(
  parameter occ_op_e    OP          = OCC_ONCE,
  parameter int         WIN_START   = 1,
  parameter int         WIN_END     = 3,
  parameter int         HIT_COUNT   = 2,
  parameter bit         FIRST_MATCH = 1'b0,
  parameter occ_track_e TRACK       = TRK_OVERLAP
) (
  input  logic clk,
  input  logic rstN,
  input  logic startI,
  input  logic operandI,
  output logic matchO,
  output logic failO
);

  localparam int SLOTS  = WIN_END;
  localparam int TARGET = (OP == OCC_COUNT) ? HIT_COUNT : 1;
  localparam int CW     = $clog2(TARGET + 1);

  logic [SLOTS-1:0]          validV;
  logic [SLOTS-1:0][CW-1:0]  cntV;
  logic                      endLive;
  logic [CW-1:0]             endCnt;
  slot_strobe_t [SLOTS-1:0]  strb;

  occ_slot_line #(
    .SLOTS (SLOTS),
    .TARGET(TARGET)
  ) u_line (
    .clk     (clk),
    .rstN    (rstN),
    .startI  (startI),
    .strbI   (strb),
    .validO  (validV),
    .cntO    (cntV),
    .endLiveO(endLive),
    .endCntO (endCnt)
  );

  occ_window_ctrl #(
    .SLOTS      (SLOTS),
    .WIN_START  (WIN_START),
    .TARGET     (TARGET),
    .OP         (OP),
    .TRACK      (TRACK),
    .FIRST_MATCH(FIRST_MATCH)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .operandI(operandI),
    .validI  (validV),
    .cntI    (cntV),
    .endLiveI(endLive),
    .endCntI (endCnt),
    .strbO   (strb),
    .matchO  (matchO),
    .failO   (failO)
  );

endmodule

// File: rtl/occ_window_sva.sv
// Checker attached to the monitor top.
module occ_window_sva
  import occ_window_pkg::*;
#(
  parameter int         SLOTS = 3,
  parameter occ_track_e TRACK = TRK_OVERLAP
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     startI,
  input logic                     matchO,
  input logic                     failO,
  input logic [SLOTS-1:0]         validV,
  input slot_strobe_t [SLOTS-1:0] strbV
);

  logic [SLOTS-1:0] creditV;
  logic [SLOTS-1:0] closeV;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      creditV[i] = strbV[i].credit;
      closeV[i]  = strbV[i].close;
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!matchO && !failO)) else $error("quiet after reset"); // R11

  AST_QUIET_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN, 2) |-> (!matchO && !failO)) else $error("quiet two cycles"); // R11

  AST_MATCH_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rstN)
    matchO |-> $past(|validV)) else $error("match without evaluation"); // R1

  AST_FAIL_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rstN)
    failO |-> $past(|validV)) else $error("fail without evaluation"); // R4

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(startI) && $past(rstN)) |-> validV[0]) else $error("start lost"); // R1

  AST_CLOSE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (closeV & ~validV) == '0) else $error("close on empty slot"); // R3

  AST_CREDIT_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (creditV & ~validV) == '0) else $error("credit on empty slot"); // R8

  generate
    for (genvar i = 1; i < SLOTS; i++) begin : g_age
      AST_AGE_STEP: assert property (@(posedge clk) disable iff (!rstN)
        validV[i] |-> $past(validV[i-1])) else $error("slot aged wrongly"); // R1
    end
    if (TRACK == TRK_PIPE) begin : g_pipe
      AST_PIPE_SINGLE_CREDIT: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(creditV)) else $error("hit shared in pipe tracking"); // R9
    end
  endgenerate

endmodule

bind occ_window_monitor occ_window_sva #(
  .SLOTS(SLOTS),
  .TRACK(TRACK)
) u_sva (
  .clk   (clk),
  .rstN  (rstN),
  .startI(startI),
  .matchO(matchO),
  .failO (failO),
  .validV(validV),
  .strbV (strb)
);

// File: tb/occ_window_monitor_tb.sv
`timescale 1ns/1ps
module occ_window_monitor_tb;
  import occ_window_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 1'b0;
  logic operandI = 1'b0;
  int   nChecks = 0;
  int   nFail = 0;

  always #2 clk = ~clk;

  logic mDut, fDut, mFirst, fFirst, mPipe, fPipe, mAlw, fAlw;
  logic mNev, fNev, mCnt, fCnt, mDly, fDly;

  occ_window_monitor #(.OP(OCC_ONCE), .WIN_START(1), .WIN_END(3), .FIRST_MATCH(1'b0),
    .TRACK(TRK_OVERLAP)) u_dut (.clk(clk), .rstN(rstN), .startI(startI),
    .operandI(operandI), .matchO(mDut), .failO(fDut));
  occ_window_monitor #(.OP(OCC_ONCE), .WIN_START(1), .WIN_END(3), .FIRST_MATCH(1'b1),
    .TRACK(TRK_OVERLAP)) u_first (.clk(clk), .rstN(rstN), .startI(startI),
    .operandI(operandI), .matchO(mFirst), .failO(fFirst));
  occ_window_monitor #(.OP(OCC_ONCE), .WIN_START(1), .WIN_END(3), .FIRST_MATCH(1'b0),
    .TRACK(TRK_PIPE)) u_pipe (.clk(clk), .rstN(rstN), .startI(startI),
    .operandI(operandI), .matchO(mPipe), .failO(fPipe));
  occ_window_monitor #(.OP(OCC_ALWAYS), .WIN_START(2), .WIN_END(4)) u_alw (.clk(clk),
    .rstN(rstN), .startI(startI), .operandI(operandI), .matchO(mAlw), .failO(fAlw));
  occ_window_monitor #(.OP(OCC_NEVER), .WIN_START(2), .WIN_END(4)) u_nev (.clk(clk),
    .rstN(rstN), .startI(startI), .operandI(operandI), .matchO(mNev), .failO(fNev));
  occ_window_monitor #(.OP(OCC_COUNT), .WIN_START(1), .WIN_END(4), .HIT_COUNT(2),
    .FIRST_MATCH(1'b1)) u_cnt (.clk(clk), .rstN(rstN), .startI(startI),
    .operandI(operandI), .matchO(mCnt), .failO(fCnt));
  occ_window_monitor #(.OP(OCC_ONCE), .WIN_START(2), .WIN_END(2)) u_dly (.clk(clk),
    .rstN(rstN), .startI(startI), .operandI(operandI), .matchO(mDly), .failO(fDly));

  // Rows: {start, operand, expected match, expected fail} for u_dut, one per cycle
  localparam int NVEC = 17;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1000, 4'b0100, 4'b0110, 4'b0110, 4'b0010, 4'b1000, 4'b0000, 4'b0000,
    4'b0000, 4'b0001, 4'b1100, 4'b1000, 4'b0100, 4'b0010, 4'b0000, 4'b0000,
    4'b0000
  };

  task automatic chk(input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // Drive one cycle's inputs at the falling edge; outputs seen afterwards
  // belong to the same cycle and reflect the previous cycle's events.
  task automatic tick(input logic s, input logic o);
    @(negedge clk);
    startI   = s;
    operandI = o;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(1'b0, 1'b0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R11: quiet while reset is held
    repeat (3) @(negedge clk);
    chk("R11 reset match", mDut | mFirst | mPipe | mAlw | mNev | mCnt | mDly, 1'b0);
    chk("R11 reset fail", fDut | fFirst | fPipe | fAlw | fNev | fCnt | fDly, 1'b0);
    rstN = 1'b1;

    // R1 R2 R4: table walk on the all-match overlap instance
    for (int k = 0; k < NVEC; k++) begin
      tick(VEC[k][3], VEC[k][2]);
      chk($sformatf("R2 row %0d match", k), mDut, VEC[k][1]);
      chk($sformatf("R4 row %0d fail", k), fDut, VEC[k][0]);
    end
    idle(6);

    // R3: first-match closes after the first hit
    tick(1, 0); tick(0, 1); tick(0, 1);
    chk("R3 first hit match", mFirst, 1'b1);
    tick(0, 1);
    chk("R3 no second match", mFirst, 1'b0);
    tick(0, 0);
    chk("R3 no third match", mFirst, 1'b0);
    tick(0, 0);
    chk("R3 no fail after match", fFirst, 1'b0);
    idle(6);

    // R9 vs R8: two overlapping starts, one shared hit
    tick(1, 0); tick(1, 0); tick(0, 1); tick(0, 0);
    chk("R9 oldest matched", mPipe, 1'b1);
    chk("R8 overlap matched", mDut, 1'b1);
    tick(0, 0);
    chk("R9 no early fail", fPipe, 1'b0);
    tick(0, 0);
    chk("R9 younger fails", fPipe, 1'b1);
    chk("R8 younger satisfied too", fDut, 1'b0);
    idle(6);

    // R6: always, good window (low before window ignored)
    tick(1, 0); tick(0, 0); tick(0, 1);
    chk("R6 low outside window ignored", fAlw, 1'b0);
    tick(0, 1); tick(0, 1); tick(0, 0);
    chk("R6 all-high match", mAlw, 1'b1);
    chk("R6 all-high no fail", fAlw, 1'b0);
    idle(6);
    // R6: always, low at offset 3
    tick(1, 0); tick(0, 1); tick(0, 1); tick(0, 0); tick(0, 0);
    chk("R6 low fails", fAlw, 1'b1);
    tick(0, 0);
    chk("R6 closed no refail", fAlw, 1'b0);
    chk("R6 closed no match", mAlw, 1'b0);
    idle(6);

    // R7: never, good window (high before window ignored)
    tick(1, 0); tick(0, 1); tick(0, 0);
    chk("R7 high outside window ignored", fNev, 1'b0);
    tick(0, 0); tick(0, 0); tick(0, 0);
    chk("R7 all-low match", mNev, 1'b1);
    idle(6);
    // R7: never, high at offset 3
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1); tick(0, 1);
    chk("R7 high fails", fNev, 1'b1);
    tick(0, 0);
    chk("R7 closed no refail", fNev, 1'b0);
    chk("R7 closed no match", mNev, 1'b0);
    idle(6);

    // R5: count of two, satisfied at offset 3
    tick(1, 0); tick(0, 1); tick(0, 0);
    chk("R5 one hit no match", mCnt, 1'b0);
    tick(0, 1); tick(0, 1);
    chk("R5 second hit match", mCnt, 1'b1);
    tick(0, 0);
    chk("R5 closed no match", mCnt, 1'b0);
    chk("R5 satisfied no fail", fCnt, 1'b0);
    idle(6);
    // R5: only one hit
    tick(1, 0); tick(0, 1); tick(0, 0); tick(0, 0); tick(0, 0);
    chk("R5 short no match", mCnt, 1'b0);
    tick(0, 0);
    chk("R5 short fails", fCnt, 1'b1);
    idle(6);

    // R10: fixed delay of two
    tick(1, 0); tick(0, 1); tick(0, 0);
    chk("R10 offset 1 ignored", mDly, 1'b0);
    tick(0, 0);
    chk("R10 miss fails", fDly, 1'b1);
    chk("R10 miss no match", mDly, 1'b0);
    idle(6);
    tick(1, 0); tick(0, 0); tick(0, 1); tick(0, 0);
    chk("R10 hit matches", mDly, 1'b1);
    chk("R10 hit no fail", fDly, 1'b0);
    idle(6);

    // R11: reset drops a live evaluation
    tick(1, 0);
    @(negedge clk);
    startI = 1'b0; operandI = 1'b1; rstN = 1'b0;
    chk("R11 in reset", mDut, 1'b0);
    tick(0, 1);
    rstN = 1'b1;
    chk("R11 first cycle after", mDut | fDut, 1'b0);
    tick(0, 1);
    chk("R11 second cycle after", mDut | fDut, 1'b0);
    tick(0, 0);
    chk("R11 evaluation gone match", mDut, 1'b0);
    tick(0, 0);
    chk("R11 evaluation gone fail", fDut, 1'b0);
    tick(0, 0);
    chk("R11 late fail absent", fDut, 1'b0);

    finishRun();
  end

endmodule